// File: doc/BRIEF.md
# Triggered Frame Capture Buffer

This block takes a continuous stream of 16-bit pixel samples from a scanned image sensor. It keeps exactly one frame in a dual-port block RAM. Samples arrive as single-cycle valid strobes, at a rate far below the system clock. A frame-start marker flags the first pixel of each frame. While the block is idle the stream is dropped. A trigger arms the block. The block then waits for the next frame-start marker and stores that pixel at address zero, followed by every later valid sample at rising addresses.

After the last address has been written, the block stops writing and freezes the memory. It then raises a ready flag toward a reader. The reader fetches pixels through the second RAM port at its own pace. When the reader pulses an acknowledge, the flag clears and the block again accepts a trigger. The read port is always live and is never used for writing. The frame depth is a parameter, and the address width follows from it.

Top module: `frame_grab_top`

## Requirements
- R1: A synchronous active-high reset returns the block to idle with `frame_ready` low. An interrupted capture does not resume, so samples that follow reset without a new trigger never raise `frame_ready`.
- R2: While idle (no trigger accepted), incoming samples are not written. Memory read back afterwards still holds the previously captured frame.
- R3: After a trigger, samples that arrive before the next sample flagged with `smp_sof` are discarded. The flagged sample is stored at address 0 and each later valid sample at the next address.
- R4: Writing stops once address `DEPTH-1` has been written. `frame_ready` rises on the clock edge that writes that address, and samples arriving afterwards leave memory unchanged.
- R5: `frame_ready` stays high until a cycle with `ready_ack` high. It is low from the following cycle on, and the block is then idle and accepts a trigger.
- R6: A trigger during capture, or while `frame_ready` is high, has no effect. A capture in progress is not restarted, and a trigger seen while `frame_ready` is high does not start a capture after the acknowledge. An `smp_sof` during capture is stored as an ordinary pixel.
- R7: `rd_data` presents the word at `rd_addr` one clock after `rd_addr` is sampled.
- R8: Only cycles with `smp_valid` high are written. Data present while `smp_valid` is low is never stored.
- R9: `frame_ready` stays low after `DEPTH-1` stored samples and rises only with the `DEPTH`-th.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Single-cycle strobe marking a new pixel sample |
| smp_data | input | 16 | Pixel sample value |
| smp_sof | input | 1 | Marks the sample as the first pixel of a frame |
| trig | input | 1 | Capture request, honoured only while idle |
| ready_ack | input | 1 | Reader acknowledge; clears `frame_ready` and re-arms |
| rd_addr | input | AW | Read port address |
| rd_data | output | 16 | Read port data, one cycle latency |
| frame_ready | output | 1 | A complete frame is held in memory |

## Verification
The bench goes after alignment first. It triggers in the middle of a frame and checks that address 0 holds the marked pixel, not the first sample after the trigger. A design that started writing on the trigger would show shifted pixels. It then pulses the trigger and a stray frame marker during capture, and a trigger while the frame is held. A design that restarted on either would show early pixels overwritten, or would start a capture that nobody asked for. Junk data is driven in the gaps between valid strobes, extra samples follow the final address, and a full frame is streamed after the acknowledge without a trigger. Writes that leak in any of these cases show up as corrupted read-back. A reset in the middle of a capture, followed by an untriggered frame, catches a design whose pointer or state survives reset.

// File: rtl/fgb_pkg.sv
package fgb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_FILL  = 2'd2,
    ST_HELD  = 2'd3
  } grab_state_t;

endpackage

// File: rtl/fgb_wrptr.sv
module fgb_wrptr #(
  parameter int DEPTH = 512,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          at_last
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  assign at_last = (addr == LAST_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (step) begin
      addr <= at_last ? '0 : addr + 1'b1;
    end else if (clr) begin
      addr <= '0;
    end
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
    addr <= LAST_ADDR); // R9

endmodule

// File: rtl/fgb_dpram.sv
module fgb_dpram #(
  parameter int DEPTH = 512,
  parameter int DW    = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[wa] <= wd;
    end
  end

  always_ff @(posedge clk) begin
    rd <= mem[ra];
  end

endmodule

// File: rtl/fgb_ctrl.sv
module fgb_ctrl
  import fgb_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trig,
  input  logic          ready_ack,
  input  logic          smp_valid,
  input  logic          smp_sof,
  input  logic          ptr_last,
  input  logic [AW-1:0] ptr_addr,
  output logic          wr_en,
  output logic          ptr_clr,
  output logic          frame_ready
);

  grab_state_t st, st_nxt;

  always_comb begin
    wr_en = 1'b0;
    unique case (st)
      ST_ARMED: wr_en = smp_valid && smp_sof;
      ST_FILL:  wr_en = smp_valid;
      default:  wr_en = 1'b0;
    endcase
  end

  assign ptr_clr = (st == ST_IDLE);

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_IDLE:  if (trig) st_nxt = ST_ARMED;
      ST_ARMED: if (wr_en) st_nxt = ptr_last ? ST_HELD : ST_FILL;
      ST_FILL:  if (wr_en && ptr_last) st_nxt = ST_HELD;
      ST_HELD:  if (ready_ack) st_nxt = ST_IDLE;
      default:  st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      frame_ready <= 1'b0;
    end else begin
      st          <= st_nxt;
      frame_ready <= (st_nxt == ST_HELD);
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> !frame_ready); // R1
  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wr_en && st == ST_ARMED) |-> (ptr_addr == '0)); // R3
  AST_NO_WR_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
    frame_ready |-> !wr_en); // R4
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (frame_ready && !ready_ack) |=> frame_ready); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (frame_ready && ready_ack) |=> !frame_ready); // R5
  AST_WR_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> smp_valid); // R8

endmodule

// File: rtl/frame_grab_top.sv
module frame_grab_top #(
  parameter int DEPTH = 512,
  parameter int DW    = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic          smp_sof,
  input  logic          trig,
  input  logic          ready_ack,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          frame_ready
);

  logic          wr_en;
  logic          ptr_clr;
  logic          ptr_last;
  logic [AW-1:0] wr_addr;

  fgb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .trig        (trig),
    .ready_ack   (ready_ack),
    .smp_valid   (smp_valid),
    .smp_sof     (smp_sof),
    .ptr_last    (ptr_last),
    .ptr_addr    (wr_addr),
    .wr_en       (wr_en),
    .ptr_clr     (ptr_clr),
    .frame_ready (frame_ready)
  );

  fgb_wrptr #(.DEPTH(DEPTH)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .clr     (ptr_clr),
    .step    (wr_en),
    .addr    (wr_addr),
    .at_last (ptr_last)
  );

  fgb_dpram #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk (clk),
    .we  (wr_en),
    .wa  (wr_addr),
    .wd  (smp_data),
    .ra  (rd_addr),
    .rd  (rd_data)
  );

endmodule

// File: tb/sim_frame_grab_top.sv
module sim_frame_grab_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          smp_valid = 1'b0;
  logic [15:0]   smp_data = '0;
  logic          smp_sof = 1'b0;
  logic          trig = 1'b0;
  logic          ready_ack = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [15:0]   rd_data;
  logic          frame_ready;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [DEPTH];
  logic [15:0] exp_q [$];
  int          addr_q [$];
  string       tag_q [$];
  logic        rd_req = 1'b0;
  logic        mon_pend = 1'b0;
  bit          done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_grab_top #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_sof(smp_sof), .trig(trig), .ready_ack(ready_ack),
    .rd_addr(rd_addr), .rd_data(rd_data), .frame_ready(frame_ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: compares read data one cycle after the address was driven
  always @(posedge clk) mon_pend <= rd_req;
  always @(negedge clk) begin
    if (mon_pend && exp_q.size() > 0) begin
      logic [15:0] e;
      int a;
      string t;
      e = exp_q.pop_front();
      a = addr_q.pop_front();
      t = tag_q.pop_front();
      check(rd_data == e, $sformatf("%s R7 addr %0d", t, a), rd_data, e);
    end
  end

  task automatic sample(input logic [15:0] d, input logic sof, input int gap);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = d; smp_sof = sof;
    @(negedge clk);
    smp_valid = 1'b0; smp_sof = 1'b0; smp_data = 16'hDEAD ^ d; // R8 junk in gaps
    repeat (gap) @(negedge clk);
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ready_ack = 1'b1;
    @(negedge clk); ready_ack = 1'b0;
  endtask

  // driver: pushes expected words and drives the read address
  task automatic readback(input string tag);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      rd_addr = AW'(a);
      rd_req = 1'b1;
      exp_q.push_back(model[a]);
      addr_q.push_back(a);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    rd_req = 1'b0;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R7 queue drained", exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(frame_ready == 1'b0, "R1 reset state", frame_ready, 0);

    // untriggered frame is dropped
    for (int i = 0; i < DEPTH; i++) sample(16'h0100 + 16'(i), i == 0, 1);
    check(frame_ready == 1'b0, "R2 no capture without trigger", frame_ready, 0);

    // trigger mid-frame: tail of current frame must be discarded
    pulse_trig();
    for (int i = 0; i < 5; i++) sample(16'h0E00 + 16'(i), 1'b0, 0);
    check(frame_ready == 1'b0, "R3 armed, waiting for marker", frame_ready, 0);
    for (int i = 0; i < DEPTH; i++) begin
      model[i] = 16'hA000 + 16'(i * 7);
      if (i == 5) begin
        @(negedge clk); trig = 1'b1;          // R6 trigger during capture
        @(negedge clk); trig = 1'b0;
      end
      sample(model[i], (i == 0) || (i == 9), i % 3); // R6 stray marker at 9
      if (i == DEPTH - 2)
        check(frame_ready == 1'b0, "R9 low after DEPTH-1 samples", frame_ready, 0);
    end
    check(frame_ready == 1'b1, "R4 ready after last address", frame_ready, 1);
    for (int i = 0; i < 4; i++) sample(16'h5555 + 16'(i), i == 0, 0);
    pulse_trig(); // R6 trigger while held
    check(frame_ready == 1'b1, "R5 held until ack", frame_ready, 1);
    readback("R3 R4 R6 R8 frame A");

    pulse_ack();
    check(frame_ready == 1'b0, "R5 ack clears flag", frame_ready, 0);
    for (int i = 0; i < DEPTH; i++) sample(16'h7700 + 16'(i), i == 0, 0);
    check(frame_ready == 1'b0, "R6 held trigger not replayed", frame_ready, 0);
    readback("R2 memory untouched");

    // second capture, marker arrives immediately
    pulse_trig();
    for (int i = 0; i < DEPTH; i++) begin
      model[i] = 16'hC300 ^ 16'(i * 13);
      sample(model[i], i == 0, 0);
    end
    check(frame_ready == 1'b1, "R4 second frame ready", frame_ready, 1);
    readback("R3 frame C");
    pulse_ack();

    // reset during capture
    pulse_trig();
    for (int i = 0; i < 6; i++) sample(16'h3300 + 16'(i), i == 0, 0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(frame_ready == 1'b0, "R1 flag low after reset", frame_ready, 0);
    for (int i = 0; i < DEPTH + 4; i++) sample(16'h4400 + 16'(i), i == 0, 0);
    check(frame_ready == 1'b0, "R1 capture not resumed", frame_ready, 0);

    done_flag = 1'b1;
    summary();
  end

endmodule